// File: doc/BRIEF.md
# Serial Link Fault Monitor

This block sits on the recovered bit clock of a serial receiver and decides whether the incoming stream can be trusted. It first picks the stream that feeds the recovery path. That is the line input, or the local transmit stream when loopback is selected. It registers the chosen bit once per bit time and watches it for data transitions.

A three-state finite state machine tracks the health of the line:
- **LINK_LIVE**: data is moving and a quiet counter runs.
- **LINK_QUIET**: the line has gone silent, and the machine hunts for renewed activity.
- **LINK_BYPASS**: the transition detector is switched off.

The named transitions are:
- **go_quiet** (LIVE to QUIET): `QUIET_LIMIT` bit times pass without a transition.
- **regain** (QUIET to LIVE): `RECOVER_EDGES` transitions arrive within one `WINDOW`-bit observation window. A window that expires first restarts its count.
- **detector_off** (any state to BYPASS): the carrier-detect input selects the detector-off code.
- **resume** (BYPASS to LIVE): the detector is enabled again, and the quiet count starts from zero.

Reset places the machine in LINK_QUIET.

The outputs are combined from the carrier-detect control, the quiet state and an out-of-lock flag supplied by an external frequency checker:
- an active-high link-good flag;
- a gated copy of the recovered bit;
- a request that tells the clock-recovery loop to track the multiplied reference instead of the data.

Top module: `link_fault_monitor`

## Requirements
- R1: With `loop_n` low, `rec_data` equals the `tx_bit` value sampled at the previous clock edge, whatever `line_bit` does. With `loop_n` high, it follows `line_bit` the same way. Both cases apply only while no gating from R4/R5 is active.
- R2: With carrier detect valid (`cd_state` = 2'b01), `QUIET_LIMIT` (512) consecutive bit times without a transition on the sampled stream move the block to the quiet-fault state. In that state `link_ok` is 0.
- R3: In the quiet-fault state, `RECOVER_EDGES` (4) transitions inside one `WINDOW` (512) bit window return the block to live operation. If the window ends before that count is reached, the edge count restarts.
- R4: With carrier detect forced-low (`cd_state` 2'b00 or 2'b11), `link_ok` is 0, `track_ref` is 1 and `rec_data` is 0.
- R5: While the quiet fault is active and the detector is not off, `rec_data` is 0 and `track_ref` is 1.
- R6: With detector-off (`cd_state` = 2'b10), there is no quiet fault, `track_ref` is 0 and `link_ok` equals the inverse of `out_of_lock`.
- R7: With carrier detect valid, `link_ok` is 1 only when there is no quiet fault and `out_of_lock` is 0.
- R8: After the synchronous active-high reset, the block is in the quiet-fault state. With valid carrier detect this gives `link_ok` 0, `track_ref` 1 and `rec_data` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous reset, active high |
| cd_state | input | 2 | Carrier detect: 01 valid, 10 detector off, 00/11 forced low |
| line_bit | input | 1 | Serial bit from the line receiver |
| tx_bit | input | 1 | Local transmit serial bit, used in loopback |
| loop_n | input | 1 | Loopback select, active low |
| out_of_lock | input | 1 | Frequency checker reports loss of lock |
| rec_data | output | 1 | Gated recovered data bit |
| link_ok | output | 1 | Link good flag, low on fault |
| track_ref | output | 1 | Ask recovery loop to follow the reference clock |

## Verification
A quiet counter that is off by one shows up at `link_ok` and `track_ref` exactly one bit time early or late after a long idle stretch. The bench therefore compares every cycle against a reference model. A mistake in the recovery edge count or in the window restart shows up in the sparse-transition phase: there the block must stay faulted, and `rec_data` remains zeroed for hundreds of cycles. A wrong carrier-detect decode or a wrong loopback selection changes the outputs on the first clock after the stimulus, so it is seen within one bit time.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

    typedef enum logic [1:0] {
        LINK_LIVE   = 2'd0,
        LINK_QUIET  = 2'd1,
        LINK_BYPASS = 2'd2
    } link_state_e;

    localparam logic [1:0] CD_VALID   = 2'b01;
    localparam logic [1:0] CD_DET_OFF = 2'b10;

    function automatic logic cd_is_forced(input logic [1:0] cd);
        return (cd != CD_VALID) && (cd != CD_DET_OFF);
    endfunction

endpackage

// File: rtl/lfm_stream_sel.sv
module lfm_stream_sel (
    input  logic clk,
    input  logic rst,
    input  logic line_bit,
    input  logic tx_bit,
    input  logic loop_n,
    output logic samp_q,
    output logic edge_seen
);

    logic prev_q;
    logic chosen;

    always_comb chosen = loop_n ? line_bit : tx_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            samp_q <= chosen;
            prev_q <= samp_q;
        end
    end

    always_comb edge_seen = (samp_q != prev_q);

    assert_loop_src_R1: assert property (@(posedge clk) disable iff (rst)
        !loop_n |=> samp_q == $past(tx_bit));

    assert_line_src_R1: assert property (@(posedge clk) disable iff (rst)
        loop_n |=> samp_q == $past(line_bit));

endmodule

// File: rtl/lfm_quiet_fsm.sv
module lfm_quiet_fsm
    import lfm_pkg::*;
#(
    parameter int QUIET_LIMIT   = 512,
    parameter int WINDOW        = 512,
    parameter int RECOVER_EDGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic det_off,
    input  logic edge_seen,
    output logic quiet_fault
);

    localparam int QW = $clog2(QUIET_LIMIT + 1);
    localparam int WW = $clog2(WINDOW);
    localparam int EW = $clog2(RECOVER_EDGES + 1);
    localparam logic [QW-1:0] Q_LAST = QW'(QUIET_LIMIT - 1);
    localparam logic [QW-1:0] Q_SAT  = QW'(QUIET_LIMIT);
    localparam logic [WW-1:0] W_LAST = WW'(WINDOW - 1);
    localparam logic [EW-1:0] E_LAST = EW'(RECOVER_EDGES - 1);

    link_state_e     st, st_nx;
    logic [QW-1:0]   qcnt, q_nx;
    logic [WW-1:0]   wcnt, w_nx;
    logic [EW-1:0]   ecnt, e_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LINK_QUIET;
            qcnt <= '0;
            wcnt <= '0;
            ecnt <= '0;
        end else begin
            st   <= st_nx;
            qcnt <= q_nx;
            wcnt <= w_nx;
            ecnt <= e_nx;
        end
    end

    // next state and counters
    always_comb begin
        st_nx = st;
        q_nx  = qcnt;
        w_nx  = wcnt;
        e_nx  = ecnt;
        if (det_off) begin
            st_nx = LINK_BYPASS;
            q_nx  = '0;
            w_nx  = '0;
            e_nx  = '0;
        end else begin
            unique case (st)
                LINK_LIVE: begin
                    if (edge_seen) begin
                        q_nx = '0;
                    end else if (qcnt == Q_LAST) begin
                        st_nx = LINK_QUIET;
                        q_nx  = Q_SAT;
                        w_nx  = '0;
                        e_nx  = '0;
                    end else begin
                        q_nx = qcnt + 1'b1;
                    end
                end
                LINK_QUIET: begin
                    if (edge_seen && ecnt == E_LAST) begin
                        st_nx = LINK_LIVE;
                        q_nx  = '0;
                        w_nx  = '0;
                        e_nx  = '0;
                    end else if (wcnt == W_LAST) begin
                        w_nx = '0;
                        e_nx = '0;
                    end else begin
                        w_nx = wcnt + 1'b1;
                        e_nx = ecnt + EW'(edge_seen);
                    end
                end
                LINK_BYPASS: begin
                    st_nx = LINK_LIVE;
                    q_nx  = '0;
                end
                default: st_nx = LINK_QUIET;
            endcase
        end
    end

    // outputs
    always_comb quiet_fault = (st == LINK_QUIET);

    assert_quiet_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (st == LINK_QUIET && $past(st) == LINK_LIVE) |-> $past(qcnt) == Q_LAST);

    assert_live_count_R2: assert property (@(posedge clk) disable iff (rst)
        st == LINK_LIVE |-> qcnt < Q_SAT);

    assert_regain_edge_R3: assert property (@(posedge clk) disable iff (rst)
        (st == LINK_LIVE && $past(st) == LINK_QUIET) |-> $past(edge_seen));

    assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
        det_off |=> st == LINK_BYPASS);

endmodule

// File: rtl/link_fault_monitor.sv
module link_fault_monitor
    import lfm_pkg::*;
#(
    parameter int QUIET_LIMIT   = 512,
    parameter int WINDOW        = 512,
    parameter int RECOVER_EDGES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cd_state,
    input  logic       line_bit,
    input  logic       tx_bit,
    input  logic       loop_n,
    input  logic       out_of_lock,
    output logic       rec_data,
    output logic       link_ok,
    output logic       track_ref
);

    logic samp_q;
    logic edge_seen;
    logic quiet_fault;
    logic det_off;
    logic forced;
    logic quiet_act;

    always_comb begin
        det_off = (cd_state == CD_DET_OFF);
        forced  = cd_is_forced(cd_state);
    end

    lfm_stream_sel u_sel (
        .clk       (clk),
        .rst       (rst),
        .line_bit  (line_bit),
        .tx_bit    (tx_bit),
        .loop_n    (loop_n),
        .samp_q    (samp_q),
        .edge_seen (edge_seen)
    );

    lfm_quiet_fsm #(
        .QUIET_LIMIT   (QUIET_LIMIT),
        .WINDOW        (WINDOW),
        .RECOVER_EDGES (RECOVER_EDGES)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .det_off     (det_off),
        .edge_seen   (edge_seen),
        .quiet_fault (quiet_fault)
    );

    always_comb begin
        quiet_act = quiet_fault && !det_off;
        track_ref = forced || quiet_act;
        rec_data  = samp_q && !track_ref;
        if (forced)       link_ok = 1'b0;
        else if (det_off) link_ok = !out_of_lock;
        else              link_ok = !quiet_act && !out_of_lock;
    end

    assert_forced_R4: assert property (@(posedge clk) disable iff (rst)
        forced |-> (!link_ok && track_ref && !rec_data));

    assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
        track_ref |-> !rec_data);

    assert_detoff_R6: assert property (@(posedge clk) disable iff (rst)
        det_off |-> (!track_ref && link_ok == !out_of_lock));

    assert_lock_R7: assert property (@(posedge clk) disable iff (rst)
        out_of_lock |-> !link_ok);

endmodule

// File: tb/link_fault_monitor_tb_top.sv
module link_fault_monitor_tb_top;

    localparam int QL = 512;
    localparam int WN = 512;
    localparam int RE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cd_state = 2'b01;
    logic       line_bit = 1'b0;
    logic       tx_bit = 1'b0;
    logic       loop_n = 1'b1;
    logic       out_of_lock = 1'b0;
    logic       rec_data, link_ok, track_ref;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    link_fault_monitor #(.QUIET_LIMIT(QL), .WINDOW(WN), .RECOVER_EDGES(RE)) dut_i (
        .clk(clk), .rst(rst), .cd_state(cd_state), .line_bit(line_bit),
        .tx_bit(tx_bit), .loop_n(loop_n), .out_of_lock(out_of_lock),
        .rec_data(rec_data), .link_ok(link_ok), .track_ref(track_ref)
    );

    // reference model built from the requirements
    logic m_samp, m_prev;
    int   m_st;   // 0 live, 1 quiet, 2 bypass
    int   m_q, m_w, m_e;

    always @(posedge clk) begin
        if (rst) begin
            m_samp <= 1'b0; m_prev <= 1'b0;
            m_st <= 1; m_q <= 0; m_w <= 0; m_e <= 0;
        end else begin
            m_samp <= loop_n ? line_bit : tx_bit;
            m_prev <= m_samp;
            if (cd_state == 2'b10) begin
                m_st <= 2; m_q <= 0; m_w <= 0; m_e <= 0;
            end else if (m_st == 2) begin
                m_st <= 0; m_q <= 0;
            end else if (m_st == 0) begin
                if (m_samp != m_prev) m_q <= 0;
                else if (m_q == QL - 1) begin
                    m_st <= 1; m_q <= QL; m_w <= 0; m_e <= 0;
                end else m_q <= m_q + 1;
            end else begin
                if (m_samp != m_prev && m_e == RE - 1) begin
                    m_st <= 0; m_q <= 0; m_w <= 0; m_e <= 0;
                end else if (m_w == WN - 1) begin
                    m_w <= 0; m_e <= 0;
                end else begin
                    m_w <= m_w + 1;
                    m_e <= m_e + ((m_samp != m_prev) ? 1 : 0);
                end
            end
        end
    end

    function automatic logic f_forced(input logic [1:0] c);
        return !(c == 2'b01 || c == 2'b10);
    endfunction

    function automatic logic f_quiet(input int st, input logic [1:0] c);
        return (st == 1) && (c != 2'b10);
    endfunction

    task automatic check_outputs();
        logic fo, q, e_tr, e_rd, e_ok;
        string tg;
        fo   = f_forced(cd_state);
        q    = f_quiet(m_st, cd_state);
        e_tr = fo || q;
        e_rd = m_samp && !e_tr;
        e_ok = fo ? 1'b0 : (cd_state == 2'b10) ? !out_of_lock : (!q && !out_of_lock);
        if (rst)                    tg = "R8";
        else if (fo)                tg = "R4";
        else if (cd_state == 2'b10) tg = "R6";
        else if (q)                 tg = "R2/R5";
        else                        tg = "R3/R7";
        checks++;
        if (link_ok !== e_ok) begin
            errors++;
            $display("FAIL %s link_ok actual %b expected %b", tg, link_ok, e_ok);
        end
        checks++;
        if (track_ref !== e_tr) begin
            errors++;
            $display("FAIL %s track_ref actual %b expected %b", tg, track_ref, e_tr);
        end
        checks++;
        if (rec_data !== e_rd) begin
            errors++;
            $display("FAIL %s R1 rec_data actual %b expected %b", tg, rec_data, e_rd);
        end
    endtask

    task automatic step(input logic l, input logic t, input logic ln,
                        input logic [1:0] c, input logic o);
        line_bit = l; tx_bit = t; loop_n = ln; cd_state = c; out_of_lock = o;
        @(negedge clk);
        check_outputs();
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic b;
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        // R8: reset state
        repeat (3) step(1'b0, 1'b0, 1'b1, 2'b01, 1'b0);
        rst = 1'b0;
        // R3: transitions bring the link up
        for (int i = 0; i < 30; i++) step(i[0], 1'b0, 1'b1, 2'b01, 1'b0);
        // R2/R5: long idle line declares a quiet fault
        for (int i = 0; i < 600; i++) step(1'b1, 1'b0, 1'b1, 2'b01, 1'b0);
        // R3: sparse edges (3 per window) keep the fault up
        b = 1'b1;
        for (int i = 0; i < 1600; i++) begin
            if (i % 200 == 0) b = ~b;
            step(b, 1'b0, 1'b1, 2'b01, 1'b0);
        end
        // R3: dense edges recover
        for (int i = 0; i < 40; i++) step(i[1], 1'b0, 1'b1, 2'b01, 1'b0);
        // R7: out-of-lock pulses with live data
        for (int i = 0; i < 200; i++)
            step(1'($urandom), 1'b0, 1'b1, 2'b01, 1'($urandom % 4 == 0));
        // R6: detector off, idle line, random lock flag
        for (int i = 0; i < 800; i++)
            step(1'b0, 1'b0, 1'b1, 2'b10, 1'($urandom % 3 == 0));
        // R4: forced low, both codes, busy line
        for (int i = 0; i < 100; i++)
            step(1'($urandom), 1'b0, 1'b1, (i < 50) ? 2'b00 : 2'b11, 1'b0);
        // R1: loopback with idle line input
        for (int i = 0; i < 300; i++)
            step(1'b0, 1'($urandom), 1'b0, 2'b01, 1'b0);
        // mixed random traffic with idle bursts
        for (int i = 0; i < 20000; i++) begin
            logic [1:0] c;
            int r;
            r = int'($urandom % 100);
            c = (r < 85) ? 2'b01 : (r < 93) ? 2'b10 : 2'($urandom);
            if ((i / 700) % 2 == 1)
                step(1'b1, 1'b1, 1'((i / 1400) % 2), c, 1'($urandom % 20 == 0));
            else
                step(1'($urandom), 1'($urandom), 1'($urandom % 8 != 0), c,
                     1'($urandom % 20 == 0));
        end
        finish_run();
    end

endmodule